// File: doc/BRIEF.md
# Conditional Memory-Mapped Transfer Engine

This block is a single-channel transfer engine that acts as the master on a Wishbone-style shared bus. Software places a four-word instruction in a reserved region of any slave and then pulses a start input along with the word address of that instruction. The engine reads the instruction and then copies data one word at a time. Each word is fetched with a single read cycle and then stored with a single write cycle.

The source and destination addresses each have their own signed step. A step of zero holds an address fixed, which suits a FIFO port. Other steps walk through RAM with any stride. A word count of zero turns the instruction into a permanent link that runs until a stop request arrives. An optional runtime condition is tested before every word. Depending on the reaction chosen, the condition either gates the transfer (words move only while it holds), pauses it while it holds, or ends it.

Top module: `udma_engine`

## Requirements
- R1: After reset the engine is idle: `busy_o`, `done_o`, `aborted_o`, `suspended_o`, `wb_cyc_o` and `wb_stb_o` are 0, and `remain_o` is 0.
- R2: A one-cycle `start_i` while idle launches four read cycles at word addresses `ptr_i`, `ptr_i+1`, `ptr_i+2` and `ptr_i+3`. Their contents are the source address, the destination address, a step word and a control word. In the step word, bits [7:0] hold the signed source step and bits [15:8] hold the signed destination step. In the control word, bits [15:0] hold the count N, bits [17:16] the condition selector and bits [19:18] the reaction.
- R3: Every data word is a read cycle at the current source address followed by a write cycle at the current destination address. The write carries the data returned by that read. `wb_we_o` is 1 only in write cycles, and `wb_sel_o` is all ones.
- R4: Once `wb_stb_o` is raised, it stays high with `wb_cyc_o`, and the address and `wb_we_o` stay unchanged, until `wb_ack_i` is seen. There is no timeout.
- R5: After each word, each address advances by its own sign-extended step. A step of 0 keeps that address fixed.
- R6: With N greater than 0, exactly N words move. `remain_o` counts down from N, then `done_o` is set and `busy_o` falls.
- R7: With N equal to 0 the engine copies without end. A `stop_i` pulse while busy ends it at the next word boundary and sets `done_o`.
- R8: Condition selector encoding: 0 means no condition, and the reaction is ignored. 1 means `flag_a_i` is high. 2 means `counter_i` equals `compare_i`. 3 means `timer_i` is greater than `limit_i`. The condition is tested before each word.
- R9: Reaction 2 (abort): if the condition holds at a word boundary, the engine ends with `aborted_o` set and starts no further bus cycle.
- R10: Reaction 1 (suspend): while the condition holds at a word boundary, no bus cycle starts and `suspended_o` is 1. The transfer resumes once the condition clears.
- R11: Reaction 0 (activate): words move only while the condition holds. Otherwise the engine waits with `suspended_o` set.
- R12: `done_o` and `aborted_o` are never set together. Both are cleared by the next start, and one of them is set whenever `busy_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch instruction fetch (ignored while busy) |
| ptr_i | input | 32 | Word address of the instruction |
| stop_i | input | 1 | Soft stop at the next word boundary |
| flag_a_i | input | 1 | External condition flag |
| counter_i | input | 16 | Counter value for the equality condition |
| compare_i | input | 16 | Compare value for the equality condition |
| timer_i | input | 16 | Timer value for the limit condition |
| limit_i | input | 16 | Limit for the timer condition |
| wb_adr_o | output | 32 | Bus word address |
| wb_dat_i | input | 32 | Bus read data |
| wb_dat_o | output | 32 | Bus write data |
| wb_we_o | output | 1 | Write enable |
| wb_sel_o | output | 4 | Byte selects |
| wb_stb_o | output | 1 | Strobe |
| wb_cyc_o | output | 1 | Cycle valid |
| wb_ack_i | input | 1 | Slave acknowledge |
| busy_o | output | 1 | Engine active |
| done_o | output | 1 | Last transfer completed or was stopped |
| aborted_o | output | 1 | Last transfer was aborted |
| suspended_o | output | 1 | Waiting on the condition |
| remain_o | output | 16 | Words still to move |

## Verification
The bench builds the engine with its defaults: 32-bit addresses and data, 8-bit signed steps and a 16-bit count and compare width. Step values of +1, +2, 0, -1 and +3 can then be written into the step word, which covers increasing, fixed and decreasing address walks. A 16-bit count allows runs of twenty words or more, which is long enough to raise an abort condition partway through a transfer. The slave in the bench varies its acknowledge latency from zero to two wait cycles. Every acknowledged access is compared against a model of the expected address, direction and write data.

// File: rtl/udma_pkg.sv
package udma_pkg;
  typedef enum logic [1:0] {
    COND_NONE   = 2'd0,
    COND_FLAG   = 2'd1,
    COND_CNT_EQ = 2'd2,
    COND_TMR_GT = 2'd3
  } cond_sel_e;

  typedef enum logic [1:0] {
    REACT_ACTIVATE = 2'd0,
    REACT_SUSPEND  = 2'd1,
    REACT_ABORT    = 2'd2,
    REACT_RSVD     = 2'd3
  } react_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_CHECK = 3'd2,
    ST_RD    = 3'd3,
    ST_WR    = 3'd4
  } state_e;
endpackage

// File: rtl/udma_cond.sv
module udma_cond
  import udma_pkg::*;
#(
  parameter int CMP_W = 16
) (
  input  cond_sel_e        sel_i,
  input  logic             flag_a_i,
  input  logic [CMP_W-1:0] counter_i,
  input  logic [CMP_W-1:0] compare_i,
  input  logic [CMP_W-1:0] timer_i,
  input  logic [CMP_W-1:0] limit_i,
  output logic             hit_o
);
  always_comb begin
    unique case (sel_i)
      COND_FLAG:   hit_o = flag_a_i;
      COND_CNT_EQ: hit_o = (counter_i == compare_i);
      COND_TMR_GT: hit_o = (timer_i > limit_i);
      default:     hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/udma_ptr.sv
module udma_ptr #(
  parameter int AW    = 32,
  parameter int INC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [AW-1:0]    load_val_i,
  input  logic             step_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [AW-1:0]    addr_o
);
  localparam int EXT_W = AW - INC_W;

  logic [AW-1:0] inc_ext;
  assign inc_ext = {{EXT_W{inc_i[INC_W-1]}}, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= load_val_i;
    else if (step_i) addr_o <= addr_o + inc_ext;
  end

  assert_fixed_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && inc_i == '0) |=> $stable(addr_o));
endmodule

// File: rtl/udma_engine.sv
module udma_engine
  import udma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int INC_W = 8,
  parameter int CNT_W = 16,
  parameter int CMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    ptr_i,
  input  logic             stop_i,
  input  logic             flag_a_i,
  input  logic [CMP_W-1:0] counter_i,
  input  logic [CMP_W-1:0] compare_i,
  input  logic [CMP_W-1:0] timer_i,
  input  logic [CMP_W-1:0] limit_i,
  output logic [AW-1:0]    wb_adr_o,
  input  logic [DW-1:0]    wb_dat_i,
  output logic [DW-1:0]    wb_dat_o,
  output logic             wb_we_o,
  output logic [DW/8-1:0]  wb_sel_o,
  output logic             wb_stb_o,
  output logic             wb_cyc_o,
  input  logic             wb_ack_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             aborted_o,
  output logic             suspended_o,
  output logic [CNT_W-1:0] remain_o
);
  localparam int SEL_LSB   = CNT_W;
  localparam int REACT_LSB = CNT_W + 2;
  localparam int IDX_W     = 2;
  localparam int NSIDE     = 2;

  state_e               state_q;
  logic [IDX_W-1:0]     idx_q;
  logic [AW-1:0]        ptr_q;
  logic [DW-1:0]        data_q;
  logic [INC_W-1:0]     inc_q [NSIDE];
  logic [CNT_W-1:0]     cnt_q;
  logic                 link_q, stop_q, done_q, abort_q;
  cond_sel_e            sel_q;
  react_e               react_q;
  logic [AW-1:0]        addr   [NSIDE];
  logic                 hit, hold, abort_now, finish, ack_hit;

  assign ack_hit = wb_stb_o && wb_ack_i;

  udma_cond #(.CMP_W(CMP_W)) u_cond (
    .sel_i    (sel_q),
    .flag_a_i (flag_a_i),
    .counter_i(counter_i),
    .compare_i(compare_i),
    .timer_i  (timer_i),
    .limit_i  (limit_i),
    .hit_o    (hit)
  );

  // side 0 = source, side 1 = destination
  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    udma_ptr #(.AW(AW), .INC_W(INC_W)) u_ptr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (state_q == ST_FETCH && ack_hit && idx_q == IDX_W'(g)),
      .load_val_i(wb_dat_i[AW-1:0]),
      .step_i    (state_q == ST_WR && ack_hit),
      .inc_i     (inc_q[g]),
      .addr_o    (addr[g])
    );
  end

  always_comb begin
    hold      = 1'b0;
    abort_now = 1'b0;
    if (sel_q != COND_NONE) begin
      unique case (react_q)
        REACT_ACTIVATE: hold = !hit;
        REACT_SUSPEND:  hold = hit;
        REACT_ABORT:    abort_now = hit;
        default:        ;
      endcase
    end
  end

  assign finish = stop_q || (!link_q && cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ptr_q   <= '0;
      data_q  <= '0;
      inc_q   <= '{default: '0};
      cnt_q   <= '0;
      link_q  <= 1'b0;
      stop_q  <= 1'b0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      sel_q   <= COND_NONE;
      react_q <= REACT_ACTIVATE;
    end else begin
      if (state_q != ST_IDLE && stop_i) stop_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_FETCH;
          ptr_q   <= ptr_i;
          idx_q   <= '0;
          stop_q  <= 1'b0;
          done_q  <= 1'b0;
          abort_q <= 1'b0;
        end
        ST_FETCH: if (ack_hit) begin
          if (idx_q == 2'd2) begin
            inc_q[0] <= wb_dat_i[INC_W-1:0];
            inc_q[1] <= wb_dat_i[2*INC_W-1:INC_W];
          end
          if (idx_q == 2'd3) begin
            cnt_q   <= wb_dat_i[CNT_W-1:0];
            link_q  <= (wb_dat_i[CNT_W-1:0] == '0);
            sel_q   <= cond_sel_e'(wb_dat_i[SEL_LSB +: 2]);
            react_q <= react_e'(wb_dat_i[REACT_LSB +: 2]);
            state_q <= ST_CHECK;
          end
          idx_q <= idx_q + 1'b1;
        end
        ST_CHECK: begin
          if (finish) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else if (abort_now) begin
            state_q <= ST_IDLE;
            abort_q <= 1'b1;
          end else if (!hold) begin
            state_q <= ST_RD;
          end
        end
        ST_RD: if (ack_hit) begin
          data_q  <= wb_dat_i;
          state_q <= ST_WR;
        end
        ST_WR: if (ack_hit) begin
          if (!link_q) cnt_q <= cnt_q - 1'b1;
          state_q <= ST_CHECK;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wb_cyc_o = (state_q == ST_FETCH) || (state_q == ST_RD) || (state_q == ST_WR);
    wb_stb_o = wb_cyc_o;
    wb_we_o  = (state_q == ST_WR);
    wb_sel_o = '1;
    wb_dat_o = data_q;
    unique case (state_q)
      ST_FETCH: wb_adr_o = ptr_q + AW'(idx_q);
      ST_RD:    wb_adr_o = addr[0];
      ST_WR:    wb_adr_o = addr[1];
      default:  wb_adr_o = '0;
    endcase
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign aborted_o   = abort_q;
  assign suspended_o = (state_q == ST_CHECK) && !finish && !abort_now && hold;
  assign remain_o    = cnt_q;

  assert_bus_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_stb_o && !wb_ack_i) |=> (wb_stb_o && wb_cyc_o && $stable(wb_adr_o) && $stable(wb_we_o)));

  assert_susp_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspended_o |-> !wb_cyc_o);

  assert_abort_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aborted_o |-> !wb_cyc_o);

  assert_flags_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && aborted_o));

  assert_end_flag_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o || aborted_o));

  assert_count_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && !stop_q) |-> remain_o == '0);
endmodule

// File: tb/udma_engine_bench.sv
module udma_engine_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] ptr_i = '0;
  logic        stop_i = 1'b0;
  logic        flag_a_i = 1'b0;
  logic [15:0] counter_i = '0, compare_i = '0, timer_i = '0, limit_i = '0;
  logic [31:0] wb_adr_o, wb_dat_o;
  logic [31:0] wb_dat_i = '0;
  logic        wb_we_o, wb_stb_o, wb_cyc_o;
  logic [3:0]  wb_sel_o;
  logic        wb_ack_i = 1'b0;
  logic        busy_o, done_o, aborted_o, suspended_o;
  logic [15:0] remain_o;

  always #4 clk_i = ~clk_i;

  udma_engine u_udma_engine (.*);

  logic [31:0] mem [0:1023];
  int n_chk = 0, n_bad = 0;
  int acc_k = 0, dly = 0, lat = 0, cyc = 0;
  logic [31:0] m_ptr, m_src, m_dst;
  int m_sinc, m_dinc;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // slave plus per-access reference comparison
  always @(negedge clk_i) begin
    if (wb_ack_i) begin
      wb_ack_i = 1'b0;
      dly = 0;
    end else if (wb_cyc_o && wb_stb_o) begin
      if (dly >= lat) begin
        logic [31:0] ea;
        logic        ew;
        if (acc_k < 4) begin
          ea = m_ptr + 32'(acc_k);
          ew = 1'b0;
        end else begin
          int j;
          j  = (acc_k - 4) / 2;
          ew = ((acc_k - 4) % 2) == 1;
          ea = ew ? m_dst + 32'(j * m_dinc) : m_src + 32'(j * m_sinc);
          if (ew) chk(wb_dat_o == pat(m_src + 32'(j * m_sinc)), "R3 write data", wb_dat_o, pat(m_src + 32'(j * m_sinc)));
        end
        chk(wb_adr_o == ea, acc_k < 4 ? "R2 fetch addr" : "R5 data addr", wb_adr_o, ea);
        chk(wb_we_o == ew && wb_sel_o == 4'hF, "R3 we/sel", {27'd0, wb_sel_o, wb_we_o}, {27'd0, 4'hF, ew});
        if (wb_we_o) mem[wb_adr_o[9:0]] = wb_dat_o;
        else wb_dat_i = mem[wb_adr_o[9:0]];
        wb_ack_i = 1'b1;
        acc_k++;
        lat = acc_k % 3;
      end else dly++;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic int words_moved();
    return acc_k < 4 ? 0 : (acc_k - 4) / 2;
  endfunction

  task automatic load(input logic [31:0] p, input logic [31:0] s, input logic [31:0] d,
                      input int si, input int di, input int n, input int sel, input int rc);
    m_ptr = p; m_src = s; m_dst = d; m_sinc = si; m_dinc = di;
    mem[p[9:0]]       = s;
    mem[p[9:0] + 10'd1] = d;
    mem[p[9:0] + 10'd2] = {16'd0, 8'(di), 8'(si)};
    mem[p[9:0] + 10'd3] = {12'd0, 2'(rc), 2'(sel), 16'(n)};
    acc_k = 0;
    @(negedge clk_i);
    ptr_i = p; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk_i);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = pat(32'(i));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !aborted_o && !suspended_o && !wb_cyc_o && !wb_stb_o && remain_o == 0,
        "R1 reset state", {busy_o, done_o, aborted_o, suspended_o, wb_cyc_o, remain_o}, 0);

    // R6 RAM to RAM, strides +1 / +2
    load(32'd16, 32'd100, 32'd300, 1, 2, 5, 0, 0);
    wait_idle();
    chk(done_o && !aborted_o, "R6 done after N", {done_o, aborted_o}, 2'b10);
    chk(words_moved() == 5, "R6 word count", words_moved(), 5);
    chk(remain_o == 0, "R6 remain", remain_o, 0);
    chk(mem[308] == pat(104), "R3 last word", mem[308], pat(104));

    // R5 fixed source (FIFO), decreasing destination
    load(32'd20, 32'd150, 32'd400, 0, -1, 3, 0, 2);
    wait_idle();
    chk(words_moved() == 3 && done_o, "R5 fifo to ram", words_moved(), 3);
    chk(mem[398] == pat(150), "R5 step -1", mem[398], pat(150));

    // R7 permanent link ended by stop
    mem[420] = 32'd0;
    load(32'd24, 32'd160, 32'd420, 0, 0, 0, 0, 0);
    repeat (40) @(negedge clk_i);
    chk(busy_o, "R7 link still running", busy_o, 1);
    stop_i = 1'b1; @(negedge clk_i); stop_i = 1'b0;
    wait_idle();
    chk(done_o && !aborted_o && words_moved() >= 1, "R7 stop ends link", words_moved(), 1);
    chk(mem[420] == pat(160), "R7 link data", mem[420], pat(160));

    // R9 abort on counter==compare, condition already true
    counter_i = 16'd5; compare_i = 16'd5;
    mem[430] = 32'd0;
    load(32'd28, 32'd170, 32'd430, 1, 1, 4, 2, 2);
    wait_idle();
    chk(aborted_o && !done_o, "R9 aborted flag", {done_o, aborted_o}, 2'b01);
    chk(words_moved() == 0 && mem[430] == 0, "R9 no words moved", words_moved(), 0);

    // R8 timer>limit false: abort reaction never fires; R12 flags cleared
    timer_i = 16'd3; limit_i = 16'd9;
    load(32'd32, 32'd180, 32'd440, 1, 1, 2, 3, 2);
    wait_idle();
    chk(done_o && !aborted_o && words_moved() == 2, "R12 flags cleared, R8 timer cond", {done_o, aborted_o}, 2'b10);

    // R9 abort mid-transfer
    load(32'd36, 32'd200, 32'd460, 1, 3, 20, 3, 2);
    repeat (30) @(negedge clk_i);
    timer_i = 16'd20;
    wait_idle();
    chk(aborted_o && words_moved() >= 1 && words_moved() < 20, "R9 mid abort", words_moved(), 20);
    timer_i = 16'd0;

    // R10 suspend while flag high
    flag_a_i = 1'b1; mem[520] = 32'd0;
    load(32'd40, 32'd210, 32'd520, 1, 1, 2, 1, 1);
    repeat (20) @(negedge clk_i);
    chk(suspended_o && !wb_cyc_o && remain_o == 2 && mem[520] == 0, "R10 suspended", {suspended_o, remain_o}, {1'b1, 16'd2});
    flag_a_i = 1'b0;
    wait_idle();
    chk(done_o && mem[521] == pat(211), "R10 resume", mem[521], pat(211));

    // R11 activate: waits while flag low
    mem[530] = 32'd0;
    load(32'd44, 32'd220, 32'd530, 1, 1, 2, 1, 0);
    repeat (20) @(negedge clk_i);
    chk(suspended_o && mem[530] == 0 && words_moved() == 0, "R11 gated off", suspended_o, 1);
    flag_a_i = 1'b1;
    wait_idle();
    chk(done_o && words_moved() == 2 && mem[531] == pat(221), "R11 runs when true", mem[531], pat(221));
    flag_a_i = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule